// File: doc/BRIEF.md
# Packet Page Allocator with Transmit, Receive and Completion Queues

This block owns a small pool of fixed-size packet pages (four 2 KB pages by default) for a network controller and keeps track of which are in use. Software-side commands arrive as one MMU command byte plus the current packet-number value. They can allocate a page for transmission, release pages, queue a page for sending, drop or free the oldest received page, and reset the bookkeeping. The receive path asks for pages through its own request handshake. Pages that the transmitter sends either return to the pool at once or wait in a completion queue until the interrupt unit pops them.

Allocation always takes the lowest-numbered free page. When an allocate-for-transmit command finds the pool exhausted, the stored result reads 0x80. The first later release that frees a page repeats the allocation in the same cycle, so software waiting on the allocation-done event is served without issuing another command. All three queues hold page numbers in arrival order and shift toward the head on every removal.

The receive request and the transmit output use valid/ready. `rx_req_ready` is high only when a free page and a receive-queue slot exist and no command or transmit transfer occupies the cycle. A request that is held with `rx_req_ready` low simply waits. `tx_out_valid` stays high while transmit is enabled, the queue has entries and no command is present. The head is removed only on a cycle with both valid and ready high. Commands are single-cycle strobes with no back-pressure.

Top module: `pkt_page_mgr`

## Requirements
- R1: An allocate-for-transmit command (op 1) sets the stored result to the lowest-numbered free page, marks that page used and pulses `evt_alloc_set`. It always pulses `evt_alloc_clr` in the same cycle.
- R2: With every page in use, op 1 leaves the pool unchanged, sets the result to 0x80 and does not pulse `evt_alloc_set`.
- R3: A release (op 5 with `pkt_num`, op 4 with the receive head, or an auto-released sent page) frees that page. If the stored result is 0x80, the lowest free page is allocated in that same cycle, the result takes its number and `evt_alloc_set` pulses.
- R4: The operation is taken from `cmd_byte[7:5]`, and bits 4:0 are ignored. The codes are: 0 no-op, 1 allocate for transmit, 2 MMU reset, 3 drop receive head, 4 drop receive head and free its page, 5 free `pkt_num`, 6 enqueue `pkt_num` for transmit, 7 transmit queue reset. Op 0 changes no output.
- R5: Op 2 empties the pool, all three queues and sets the stored result to 0.
- R6: Op 7 empties the transmit queue and the completion queue. It leaves the pool and the receive queue alone.
- R7: `rx_head` and `done_head` read 0x80 when their queue is empty. Otherwise they read the head page number, zero-extended.
- R8: While `tx_enable` is high, queued pages leave on `tx_out_page` in enqueue order, one per accepted transfer, until the transmit queue is empty. With `tx_enable` low, `tx_out_valid` stays low.
- R9: Each sent page is freed at once when `auto_release` is high. Otherwise it is appended to the completion queue if that queue has room. `done_pop` removes the completion head.
- R10: Op 6 with the transmit queue full is ignored.
- R11: `used_count` equals the number of pages in use, and `mem_pages` reads the pool size (4 by default).
- R12: An accepted receive request takes the lowest free page, offered on `rx_alloc_page` during the handshake, and appends it to the receive queue. Op 3 removes the receive head without freeing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_byte | input | 8 | MMU command byte, operation in bits 7:5 |
| pkt_num | input | PW (2) | Packet-number register value used by ops 5 and 6 |
| tx_enable | input | 1 | Transmitter enabled |
| auto_release | input | 1 | Free pages as they are sent |
| rx_req_valid | input | 1 | Receive path requests a page |
| rx_req_ready | output | 1 | Page available for the receive request |
| rx_alloc_page | output | PW (2) | Page granted to the receive request |
| tx_out_valid | output | 1 | A queued page is offered for sending |
| tx_out_ready | input | 1 | Transmitter takes the offered page |
| tx_out_page | output | PW (2) | Page offered for sending |
| done_pop | input | 1 | Remove the completion-queue head |
| alloc_result | output | 8 | Stored transmit allocation result, 0x80 on failure |
| rx_head | output | 8 | Receive-queue head or 0x80 |
| done_head | output | 8 | Completion-queue head or 0x80 |
| tx_level | output | LW (3) | Transmit-queue entries |
| rx_level | output | LW (3) | Receive-queue entries |
| done_level | output | LW (3) | Completion-queue entries |
| used_count | output | LW (3) | Pages in use |
| mem_pages | output | LW (3) | Pool size |
| evt_alloc_clr | output | 1 | Pulse: clear the allocation-done interrupt |
| evt_alloc_set | output | 1 | Pulse: raise the allocation-done interrupt |

## Verification
The bench builds the block with its default of four pages and four-entry queues. With that size a handful of commands fills the pool, so the failed allocation and its later automatic retry can be reached. It also reaches a full transmit queue, a full completion queue and receive back-pressure. The sent-page order is compared against a scoreboard for both the completion and the auto-release policies.

// File: rtl/pkt_page_pkg.sv
package pkt_page_pkg;
  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_ALLOC_TX = 3'd1,
    OP_MMU_RST  = 3'd2,
    OP_RX_DROP  = 3'd3,
    OP_RX_FREE  = 3'd4,
    OP_REL_PNUM = 3'd5,
    OP_TX_ENQ   = 3'd6,
    OP_TX_RST   = 3'd7
  } mmu_op_e;

  localparam logic [7:0] NO_PAGE = 8'h80;
endpackage

// File: rtl/page_fifo.sv
module page_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  slot [DEPTH];
  logic [LW-1:0] cnt;
  logic          do_pop, do_push;
  logic [IW-1:0] wr_idx;

  assign empty  = (cnt == '0);
  assign full   = (cnt == LW'(DEPTH));
  assign do_pop = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign wr_idx = IW'(cnt - LW'(do_pop));
  assign dout   = slot[0];
  assign level  = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else begin
      if (do_pop) begin
        for (int i = 0; i < DEPTH - 1; i++) slot[i] <= slot[i+1];
      end
      if (do_push) slot[wr_idx] <= din;
      cnt <= cnt + LW'(do_push) - LW'(do_pop);
    end
  end
endmodule

// File: rtl/page_pick.sv
module page_pick #(
  parameter int N  = 4,
  parameter int PW = $clog2(N)
) (
  input  logic [N-1:0]  used_map,
  output logic          found,
  output logic [PW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!used_map[i]) begin
        found = 1'b1;
        idx   = PW'(i);
      end
    end
  end
endmodule

// File: rtl/pkt_page_mgr.sv
module pkt_page_mgr
  import pkt_page_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  parameter int PW        = $clog2(NUM_PAGES),
  parameter int LW        = $clog2(NUM_PAGES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_byte,
  input  logic [PW-1:0] pkt_num,
  input  logic          tx_enable,
  input  logic          auto_release,
  input  logic          rx_req_valid,
  output logic          rx_req_ready,
  output logic [PW-1:0] rx_alloc_page,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [PW-1:0] tx_out_page,
  input  logic          done_pop,
  output logic [7:0]    alloc_result,
  output logic [7:0]    rx_head,
  output logic [7:0]    done_head,
  output logic [LW-1:0] tx_level,
  output logic [LW-1:0] rx_level,
  output logic [LW-1:0] done_level,
  output logic [LW-1:0] used_count,
  output logic [LW-1:0] mem_pages,
  output logic          evt_alloc_clr,
  output logic          evt_alloc_set
);
  logic [NUM_PAGES-1:0] map_q, map_d, map_after_rel, rel_mask;
  logic [7:0]           result_q, result_d;
  mmu_op_e              op;
  logic c_alloc, c_mrst, c_rxdrop, c_rxfree, c_rel, c_enq, c_txrst;
  logic now_found, rel_found, rel_en, retry, tx_fire, rx_fire;
  logic [PW-1:0] now_idx, rel_pick, rel_idx;
  logic [PW-1:0] rx_hd, tx_hd, dn_hd;
  logic rx_full, rx_empty, tx_full, tx_empty, dn_full, dn_empty;

  assign op       = mmu_op_e'(cmd_byte[7:5]);
  assign c_alloc  = cmd_valid && (op == OP_ALLOC_TX);
  assign c_mrst   = cmd_valid && (op == OP_MMU_RST);
  assign c_rxdrop = cmd_valid && (op == OP_RX_DROP);
  assign c_rxfree = cmd_valid && (op == OP_RX_FREE);
  assign c_rel    = cmd_valid && (op == OP_REL_PNUM);
  assign c_enq    = cmd_valid && (op == OP_TX_ENQ);
  assign c_txrst  = cmd_valid && (op == OP_TX_RST);

  page_pick #(.N(NUM_PAGES), .PW(PW)) u_pick_now (
    .used_map(map_q), .found(now_found), .idx(now_idx));
  page_pick #(.N(NUM_PAGES), .PW(PW)) u_pick_rel (
    .used_map(map_after_rel), .found(rel_found), .idx(rel_pick));

  // Handshakes: commands own the cycle, then transmit, then receive.
  assign tx_out_valid  = tx_enable && !tx_empty && !cmd_valid;
  assign tx_fire       = tx_out_valid && tx_out_ready;
  assign tx_out_page   = tx_hd;
  assign rx_req_ready  = now_found && !rx_full && !cmd_valid && !tx_out_valid;
  assign rx_fire       = rx_req_valid && rx_req_ready;
  assign rx_alloc_page = now_idx;

  always_comb begin
    rel_en  = 1'b0;
    rel_idx = '0;
    if (c_rel) begin
      rel_en  = 1'b1;
      rel_idx = pkt_num;
    end else if (c_rxfree && !rx_empty) begin
      rel_en  = 1'b1;
      rel_idx = rx_hd;
    end else if (tx_fire && auto_release) begin
      rel_en  = 1'b1;
      rel_idx = tx_hd;
    end
  end

  assign rel_mask      = rel_en ? (NUM_PAGES'(1) << rel_idx) : '0;
  assign map_after_rel = map_q & ~rel_mask;
  assign retry         = rel_en && (result_q == NO_PAGE) && rel_found;

  always_comb begin
    map_d    = map_after_rel;
    result_d = result_q;
    if (c_mrst) begin
      map_d    = '0;
      result_d = 8'h00;
    end else if (c_alloc) begin
      if (now_found) begin
        map_d    = map_q | (NUM_PAGES'(1) << now_idx);
        result_d = 8'(now_idx);
      end else begin
        result_d = NO_PAGE;
      end
    end else begin
      if (retry) begin
        map_d    = map_d | (NUM_PAGES'(1) << rel_pick);
        result_d = 8'(rel_pick);
      end
      if (rx_fire) map_d = map_d | (NUM_PAGES'(1) << now_idx);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q    <= '0;
      result_q <= 8'h00;
    end else begin
      map_q    <= map_d;
      result_q <= result_d;
    end
  end

  assign evt_alloc_clr = c_alloc;
  assign evt_alloc_set = (c_alloc && now_found) || (!c_mrst && retry);

  page_fifo #(.DEPTH(NUM_PAGES), .W(PW), .LW(LW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(c_mrst),
    .push(rx_fire), .din(now_idx), .pop(c_rxdrop || c_rxfree),
    .dout(rx_hd), .level(rx_level), .full(rx_full), .empty(rx_empty));

  page_fifo #(.DEPTH(NUM_PAGES), .W(PW), .LW(LW)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(c_mrst || c_txrst),
    .push(c_enq), .din(pkt_num), .pop(tx_fire),
    .dout(tx_hd), .level(tx_level), .full(tx_full), .empty(tx_empty));

  page_fifo #(.DEPTH(NUM_PAGES), .W(PW), .LW(LW)) u_doneq (
    .clk(clk), .rst_n(rst_n), .clr(c_mrst || c_txrst),
    .push(tx_fire && !auto_release), .din(tx_hd), .pop(done_pop),
    .dout(dn_hd), .level(done_level), .full(dn_full), .empty(dn_empty));

  assign alloc_result = result_q;
  assign rx_head      = rx_empty ? NO_PAGE : 8'(rx_hd);
  assign done_head    = dn_empty ? NO_PAGE : 8'(dn_hd);
  assign used_count   = LW'($countones(map_q));
  assign mem_pages    = LW'(NUM_PAGES);
endmodule

// File: rtl/pkt_page_mgr_chk.sv
module pkt_page_mgr_chk #(
  parameter int NUM_PAGES = 4,
  parameter int PW        = $clog2(NUM_PAGES),
  parameter int LW        = $clog2(NUM_PAGES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [7:0]    cmd_byte,
  input logic          tx_enable,
  input logic          rx_req_ready,
  input logic          tx_out_valid,
  input logic [7:0]    alloc_result,
  input logic [7:0]    rx_head,
  input logic [7:0]    done_head,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic [LW-1:0] done_level,
  input logic [LW-1:0] used_count,
  input logic [LW-1:0] mem_pages,
  input logic          evt_alloc_set
);
  assert_alloc_fail_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte[7:5] == 3'd1 && used_count == mem_pages)
      |=> (alloc_result == 8'h80 && used_count == mem_pages));

  assert_no_set_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte[7:5] == 3'd1 && used_count == mem_pages) |-> !evt_alloc_set);

  assert_mmu_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte[7:5] == 3'd2)
      |=> (used_count == '0 && rx_level == '0 && tx_level == '0
           && done_level == '0 && alloc_result == 8'h00));

  assert_txq_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte[7:5] == 3'd7)
      |=> (tx_level == '0 && done_level == '0 && $stable(used_count) && $stable(rx_level)));

  assert_empty_heads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_level == '0) |-> (rx_head == 8'h80)) and ((done_level == '0) |-> (done_head == 8'h80)));

  assert_tx_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |-> !tx_out_valid);

  assert_used_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    used_count <= mem_pages);

  assert_rx_ready_room_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req_ready |-> (used_count < mem_pages && rx_level < mem_pages && !cmd_valid));
endmodule

bind pkt_page_mgr pkt_page_mgr_chk #(.NUM_PAGES(NUM_PAGES), .PW(PW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
  .tx_enable(tx_enable), .rx_req_ready(rx_req_ready), .tx_out_valid(tx_out_valid),
  .alloc_result(alloc_result), .rx_head(rx_head), .done_head(done_head),
  .tx_level(tx_level), .rx_level(rx_level), .done_level(done_level),
  .used_count(used_count), .mem_pages(mem_pages), .evt_alloc_set(evt_alloc_set));

// File: tb/pkt_page_mgr_tb.sv
module pkt_page_mgr_tb;
  localparam int NP = 4;
  localparam int PW = 2;
  localparam int LW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic [PW-1:0] pkt_num = '0;
  logic tx_enable = 1'b0, auto_release = 1'b0;
  logic rx_req_valid = 1'b0, tx_out_ready = 1'b1, done_pop = 1'b0;
  logic rx_req_ready, tx_out_valid, evt_alloc_clr, evt_alloc_set;
  logic [PW-1:0] rx_alloc_page, tx_out_page;
  logic [7:0] alloc_result, rx_head, done_head;
  logic [LW-1:0] tx_level, rx_level, done_level, used_count, mem_pages;

  int vectors = 0;
  int errors = 0;
  int exp_q[$];
  logic s_clr, s_set, s_rdy;
  logic [PW-1:0] s_page;

  always #10 clk = ~clk;

  pkt_page_mgr #(.NUM_PAGES(NP)) u_dut (.*);

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [7:0] b, input logic [PW-1:0] pn);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_byte = b; pkt_num = pn;
    #5;
    s_clr = evt_alloc_clr; s_set = evt_alloc_set; s_rdy = rx_req_ready;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_byte = 8'h00;
  endtask

  task automatic rx_req();
    @(negedge clk);
    rx_req_valid = 1'b1;
    #5;
    s_rdy = rx_req_ready; s_page = rx_alloc_page;
    @(negedge clk);
    rx_req_valid = 1'b0;
  endtask

  // Scoreboard monitor for sent pages (R8)
  always begin
    @(negedge clk);
    #5;
    if (tx_out_valid && tx_out_ready) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected send", int'(tx_out_page), -1);
      end else begin
        check("R8 send order", int'(tx_out_page), exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    check("R11 reset used", used_count, 0);
    check("R11 mem size", mem_pages, 4);
    check("R5 reset result", alloc_result, 8'h00);
    check("R7 rx head empty", rx_head, 8'h80);
    check("R7 done head empty", done_head, 8'h80);
    check("R8 no valid when off", tx_out_valid, 0);

    // R1 lowest-first allocation
    for (int k = 0; k < 4; k++) begin
      do_cmd(8'h20, 0);
      check("R1 alloc result", alloc_result, k);
      check("R1 evt set", s_set, 1);
      check("R1 evt clr", s_clr, 1);
    end
    check("R11 used full", used_count, 4);

    // R2 exhausted pool
    do_cmd(8'h3F, 0);
    check("R2 fail code", alloc_result, 8'h80);
    check("R2 no set", s_set, 0);
    check("R2 clr", s_clr, 1);
    check("R2 pool unchanged", used_count, 4);

    // R3 release with pending failure retries
    do_cmd(8'hA0, 2);
    check("R3 retry result", alloc_result, 2);
    check("R3 retry set", s_set, 1);
    check("R3 used after retry", used_count, 4);
    do_cmd(8'hA0, 1);
    check("R3 plain release", used_count, 3);
    check("R3 result kept", alloc_result, 2);
    check("R3 no set", s_set, 0);

    // R4 no-op with low bits set
    do_cmd(8'h1F, 3);
    check("R4 nop used", used_count, 3);
    check("R4 nop txq", tx_level, 0);
    check("R4 nop result", alloc_result, 2);
    check("R12 not ready during cmd", s_rdy, 0);

    // R10 fill transmit queue, extra ignored
    do_cmd(8'hC0, 0); do_cmd(8'hC0, 2); do_cmd(8'hC0, 3); do_cmd(8'hC0, 1);
    check("R10 txq full", tx_level, 4);
    do_cmd(8'hC0, 0);
    check("R10 extra ignored", tx_level, 4);

    // R8/R9 send with completion queue
    exp_q.push_back(0); exp_q.push_back(2); exp_q.push_back(3); exp_q.push_back(1);
    @(negedge clk);
    tx_enable = 1'b1;
    repeat (6) @(negedge clk);
    check("R8 txq drained", tx_level, 0);
    check("R8 scoreboard empty", exp_q.size(), 0);
    check("R9 done level", done_level, 4);
    check("R9 done head", done_head, 0);
    check("R9 no release", used_count, 3);
    tx_enable = 1'b0;
    done_pop = 1'b1;
    @(negedge clk);
    done_pop = 1'b0;
    check("R9 done pop head", done_head, 2);
    check("R9 done pop level", done_level, 3);

    // R6 transmit queue reset
    do_cmd(8'hC0, 3);
    do_cmd(8'hE0, 0);
    check("R6 txq cleared", tx_level, 0);
    check("R6 done cleared", done_level, 0);
    check("R7 done head after reset", done_head, 8'h80);
    check("R6 pool kept", used_count, 3);

    // R9 auto-release
    tx_enable = 1'b1; auto_release = 1'b1;
    exp_q.push_back(3);
    do_cmd(8'hC0, 3);
    @(negedge clk);
    check("R9 auto released", used_count, 2);
    check("R9 no completion", done_level, 0);
    tx_enable = 1'b0; auto_release = 1'b0;

    // R5 MMU reset
    do_cmd(8'h40, 0);
    check("R5 used", used_count, 0);
    check("R5 result", alloc_result, 0);
    check("R5 rx level", rx_level, 0);

    // R12 receive allocation
    rx_req();
    check("R12 ready", s_rdy, 1);
    check("R12 page0", s_page, 0);
    rx_req();
    check("R12 page1", s_page, 1);
    check("R12 rx level", rx_level, 2);
    check("R7 rx head", rx_head, 0);
    do_cmd(8'h60, 0);
    check("R12 drop head", rx_head, 1);
    check("R12 drop keeps page", used_count, 2);
    do_cmd(8'h80, 0);
    check("R7 rx head emptied", rx_head, 8'h80);
    check("R3 rx free releases", used_count, 1);

    // Fill pool through receive, then pending retry via op 4
    rx_req(); check("R12 page1 again", s_page, 1);
    rx_req(); check("R12 page2", s_page, 2);
    rx_req(); check("R12 page3", s_page, 3);
    check("R11 used 4", used_count, 4);
    rx_req();
    check("R12 back-pressure", s_rdy, 0);
    check("R12 no push when stalled", rx_level, 3);
    do_cmd(8'h20, 0);
    check("R2 fail again", alloc_result, 8'h80);
    do_cmd(8'h80, 0);
    check("R3 retry via rx free", alloc_result, 1);
    check("R3 retry set rx", s_set, 1);
    check("R3 used", used_count, 4);
    check("R12 rx head next", rx_head, 2);

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule